// File: doc/BRIEF.md
# Dual Countdown Timer Peripheral

This peripheral places two independent down-counting timer channels behind one 4 KB register window. Each channel owns a 32-byte slice at the bottom of the window and counts on its own tick input. A tick can be divided by 1, 16 or 256 before it reaches the counter. A channel runs in one of three modes. In periodic mode it reloads from its limit. In free-running mode it wraps to the largest value of its width. In one-shot mode it stops at zero. A channel sets a sticky interrupt flag when its count steps from one to zero. Both channels' enabled flags are ORed onto a single interrupt line.

The top eight words of the window return a fixed identification byte table. Two test-register words read as zero and do nothing. Every other address reads as zero. Reads are registered and always take one cycle.

Top module: `twin_timer`

## Requirements
- R1: Byte offsets 0x000–0x01F select channel 0 and 0x020–0x03F select channel 1, using local offset = address minus window base. Each write reaches at most one channel. Address bits [1:0] are ignored.
- R2: The words at 0xFE0, 0xFE4, … 0xFFC read as the zero-extended bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order, and cannot be written.
- R3: Words 0xF00 and 0xF04 read zero and writes to them have no effect. Every other unmapped offset reads zero. Writes outside the two channel windows change nothing.
- R4: `rdata` updates at the clock edge that samples `rd_en` high and holds its value in every other cycle.
- R5: Channel local map: 0x00 control, 0x04 reload, 0x08 deferred reload, 0x0C count (read-only), 0x10 flag clear (write-only, reads zero), 0x14 raw flag in bit 0, 0x18 masked flag in bit 0, 0x1C reads zero. After reset, control reads 0x40 and all other registers read 0.
- R6: Control bits are [0] run, [1] periodic, [2] one-shot, [3] 32-bit width, [5:4] prescale, [6] interrupt enable. Writing the reload word sets both the limit and the count. Writing the deferred reload word sets only the limit. Writes to the count word are ignored.
- R7: While run is set, the count drops by one per prescaled tick. Prescale code 1 passes every 16th tick, code 2 every 256th tick, and codes 0 and 3 pass every tick. Writing control restarts the prescale phase. While run is clear, the count does not move.
- R8: A prescaled tick that takes the count from 1 to 0 sets the raw flag. Writing the clear word resets the flag. When both happen in the same cycle, setting wins.
- R9: A prescaled tick at count 0 has an effect that depends on the mode. One-shot (checked first) holds the count at 0 with no new flag. Periodic loads the limit. Otherwise the count wraps to 0xFFFF (16-bit width) or 0xFFFFFFFF (32-bit width).
- R10: In 16-bit width, a value loaded into the count is truncated to its low 16 bits. The limit register still reads back the full written word.
- R11: The masked flag is the raw flag ANDed with interrupt enable. `irq` is high whenever either channel's masked flag is high.
- R12: Each channel counts only on its own tick input bit. Activity in one channel leaves the other channel's count and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 2 | Per-channel count-rate pulses (bit n drives channel n) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset into the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check four things: that writes reach at most one channel, that read data holds between strobes, that the first ID word and the test words decode correctly, and that the interrupt line equals the merge of both channels' flag-and-enable pairs. They also check that the raw flag rises only with the count at zero, and that an idle channel's count never drifts. The bench scenarios cover the rest: mode-specific reload, 16- and 32-bit wrap values, the prescale dividers, deferred reload taking effect only at the next wrap, and channel independence, because each of these depends on a sequence of configuration writes and tick counts.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int DW     = 32;
  localparam int PRE_W  = 8;
  localparam int NAR_W  = 16;

  typedef enum logic [2:0] {
    RG_CTRL   = 3'd0,
    RG_LOAD   = 3'd1,
    RG_DEFER  = 3'd2,
    RG_COUNT  = 3'd3,
    RG_CLEAR  = 3'd4,
    RG_RAW    = 3'd5,
    RG_MASKED = 3'd6,
    RG_SPARE  = 3'd7
  } reg_e;

  typedef struct packed {
    logic       ie;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
    logic       periodic;
    logic       run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 7'h40;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] pre_mask(input logic [1:0] code);
    case (code)
      2'd1:    pre_mask = PRE_W'(8'h0F);
      2'd2:    pre_mask = PRE_W'(8'hFF);
      default: pre_mask = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] span_mask(input logic wide);
    span_mask = wide ? {DW{1'b1}} : DW'({NAR_W{1'b1}});
  endfunction

  function automatic logic [DW-1:0] step_count(input logic [DW-1:0] cnt,
                                               input logic [DW-1:0] limit,
                                               input ctrl_t c);
    if (cnt != '0)       step_count = cnt - 1'b1;
    else if (c.oneshot)  step_count = '0;
    else if (c.periodic) step_count = limit & span_mask(c.wide);
    else                 step_count = span_mask(c.wide);
  endfunction

endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [PRE_W-1:0] mask,
  output logic             fire
);
  logic [PRE_W-1:0] phase;

  assign fire = tick && ((phase & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase <= '0;
    else if (tick)     phase <= phase + 1'b1;
  end
endmodule

// File: rtl/dtm_decode.sv
module dtm_decode #(
  parameter int ADDR_W    = 12,
  parameter int N_CH      = 2,
  parameter int WIN_BYTES = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   ch_hit,
  output logic              id_hit,
  output logic [2:0]        loc_idx
);
  localparam int WIN_W = $clog2(WIN_BYTES);
  localparam int PG_W  = ADDR_W - WIN_W;

  logic [PG_W-1:0] page;
  logic            unused_lane;

  assign page        = addr[ADDR_W-1:WIN_W];
  assign loc_idx     = addr[WIN_W-1:2];
  assign id_hit      = (page == {PG_W{1'b1}});
  assign unused_lane = ^addr[1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign ch_hit[c] = (page == PG_W'(c));
  end
endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
  import dtm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] cnt_o,
  output logic          raw_o,
  output logic          ie_o,
  output logic          run_o,
  output logic          load_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] limit;
  logic [DW-1:0] cnt;
  logic          raw;
  logic          fire;
  logic          wr_ctrl, wr_load, wr_defer, wr_clr;
  logic          hit_zero;
  logic [DW-8:0] unused_hi;

  assign wr_ctrl   = wr_en && (reg_e'(idx) == RG_CTRL);
  assign wr_load   = wr_en && (reg_e'(idx) == RG_LOAD);
  assign wr_defer  = wr_en && (reg_e'(idx) == RG_DEFER);
  assign wr_clr    = wr_en && (reg_e'(idx) == RG_CLEAR);
  assign hit_zero  = fire && (cnt == DW'(1));
  assign unused_hi = wdata[DW-1:7];

  dtm_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wr_ctrl),
    .tick (tick && ctrl.run),
    .mask (pre_mask(ctrl.pre)),
    .fire (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RST;
      limit <= '0;
      cnt   <= '0;
      raw   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[6:0]);
      if (wr_load || wr_defer) limit <= wdata;
      if (wr_load)   cnt <= wdata & span_mask(ctrl.wide);
      else if (fire) cnt <= step_count(cnt, limit, ctrl);
      if (hit_zero)    raw <= 1'b1;
      else if (wr_clr) raw <= 1'b0;
    end
  end

  always_comb begin
    case (reg_e'(idx))
      RG_CTRL:   rd_word = DW'(ctrl);
      RG_LOAD,
      RG_DEFER:  rd_word = limit;
      RG_COUNT:  rd_word = cnt;
      RG_RAW:    rd_word = DW'(raw);
      RG_MASKED: rd_word = DW'(raw & ctrl.ie);
      default:   rd_word = '0;
    endcase
  end

  assign cnt_o  = cnt;
  assign raw_o  = raw;
  assign ie_o   = ctrl.ie;
  assign run_o  = ctrl.run;
  assign load_o = wr_load;
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import dtm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int N_CH      = 2,
  parameter int WIN_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  logic [N_CH-1:0]         ch_hit;
  logic                    id_hit;
  logic [2:0]              loc_idx;
  logic [N_CH-1:0]         ch_wsel;
  logic [N_CH-1:0][DW-1:0] ch_rd;
  logic [N_CH-1:0][DW-1:0] ch_cnt;
  logic [N_CH-1:0]         ch_raw, ch_ie, ch_run, ch_load;
  logic [DW-1:0]           rd_next;

  dtm_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr   (addr),
    .ch_hit (ch_hit),
    .id_hit (id_hit),
    .loc_idx(loc_idx)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_wsel[c] = wr_en && ch_hit[c];
    dtm_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick[c]),
      .wr_en  (ch_wsel[c]),
      .idx    (loc_idx),
      .wdata  (wdata),
      .rd_word(ch_rd[c]),
      .cnt_o  (ch_cnt[c]),
      .raw_o  (ch_raw[c]),
      .ie_o   (ch_ie[c]),
      .run_o  (ch_run[c]),
      .load_o (ch_load[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (id_hit) rd_next = DW'(id_byte(loc_idx));
    for (int c = 0; c < N_CH; c++)
      if (ch_hit[c]) rd_next = ch_rd[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign irq = |(ch_raw & ch_ie);
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [11:0] addr,
  input logic [31:0] rdata,
  input logic        irq,
  input logic [1:0]  ch_wsel,
  input logic [1:0]  ch_raw,
  input logic [1:0]  ch_ie,
  input logic [1:0]  ch_run,
  input logic [1:0]  ch_load,
  input logic [31:0] cnt0
);
  // R1
  wsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wsel));
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R3
  test_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == 12'hF00 || addr == 12'hF04) |=> rdata == 32'h0);
  // R2
  id_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 12'hFE0 |=> rdata == 32'h04);
  // R11
  irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((ch_raw[0] && ch_ie[0]) || (ch_raw[1] && ch_ie[1])));
  // R8
  raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_raw[0]) |-> cnt0 == 32'h0);
  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_run[0] && !ch_load[0] |=> $stable(cnt0));
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_en  (rd_en),
  .addr   (addr),
  .rdata  (rdata),
  .irq    (irq),
  .ch_wsel(ch_wsel),
  .ch_raw (ch_raw),
  .ch_ie  (ch_ie),
  .ch_run (ch_run),
  .ch_load(ch_load),
  .cnt0   (ch_cnt[0])
);

// File: tb/twin_timer_test.sv
module twin_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twin_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                  .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // {address, expected word}: ID table (R2), test and unmapped words (R3)
  localparam logic [43:0] VEC [13] = '{
    {12'hFE0, 32'h04}, {12'hFE4, 32'h18}, {12'hFE8, 32'h14}, {12'hFEC, 32'h00},
    {12'hFF0, 32'h0D}, {12'hFF4, 32'hF0}, {12'hFF8, 32'h05}, {12'hFFC, 32'hB1},
    {12'hF00, 32'h00}, {12'hF04, 32'h00}, {12'h040, 32'h00}, {12'hFDC, 32'h00},
    {12'h800, 32'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdc(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic ticks(input int c, input int n);
    @(negedge clk); tick[c] = 1'b1;
    repeat (n) @(negedge clk);
    tick[c] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state, R11 idle line
    chk("R11 irq after reset", 32'(irq), 0);
    rdc("R5 ctrl reset", 12'h000, 32'h40);
    rdc("R5 count reset", 12'h00C, 0);

    for (int i = 0; i < 13; i++)
      rdc("R2/R3 table", VEC[i][43:32], VEC[i][31:0]);

    // R6 reload and R1 window routing
    wr(12'h004, 5);
    rdc("R6 count loaded", 12'h00C, 5);
    rdc("R1 ch1 untouched", 12'h02C, 0);
    rdc("R6 limit readback", 12'h004, 5);

    // R7/R8/R9 periodic
    wr(12'h000, 32'h4B);
    ticks(0, 4);
    rdc("R7 count after 4", 12'h00C, 1);
    chk("R8 no flag yet", 32'(irq), 0);
    ticks(0, 1);
    chk("R8 flag at zero", 32'(irq), 1);
    ticks(0, 1);
    rdc("R9 periodic reload", 12'h00C, 5);
    rdc("R11 masked flag", 12'h018, 1);
    wr(12'h010, 32'hFFFF_FFFF);
    chk("R8 cleared irq", 32'(irq), 0);
    rdc("R8 cleared raw", 12'h014, 0);

    // R6 deferred reload
    wr(12'h008, 2);
    rdc("R6 deferred keeps count", 12'h00C, 5);
    ticks(0, 5);
    chk("R8 flag again", 32'(irq), 1);
    ticks(0, 1);
    rdc("R9 uses new limit", 12'h00C, 2);
    wr(12'h010, 0);

    // R6/R3 ignored writes
    wr(12'h00C, 32'h99);
    rdc("R6 count write ignored", 12'h00C, 2);
    wr(12'hF00, 1); wr(12'hFE0, 32'hFF); wr(12'h040, 32'h1234);
    rdc("R3 id unchanged", 12'hFE0, 32'h04);
    rdc("R3 ch0 unchanged", 12'h004, 2);
    rdc("R3 ch1 unchanged", 12'h024, 0);
    rdc("R3 test word", 12'hF00, 0);

    // R11 masking
    wr(12'h000, 32'h0B);
    ticks(0, 3);
    rdc("R11 raw set", 12'h014, 1);
    rdc("R11 masked off", 12'h018, 0);
    chk("R11 irq masked", 32'(irq), 0);
    wr(12'h000, 32'h4B);
    chk("R11 irq unmasked", 32'(irq), 1);
    wr(12'h010, 0);

    // R12 channel independence
    wr(12'h024, 3); wr(12'h020, 32'h4B);
    ticks(1, 3);
    chk("R12 ch1 irq", 32'(irq), 1);
    rdc("R12 ch0 count", 12'h00C, 2);
    rdc("R12 ch0 raw", 12'h014, 0);
    rdc("R12 ch1 raw", 12'h034, 1);
    wr(12'h030, 0);
    chk("R12 ch1 cleared", 32'(irq), 0);

    // R10/R9 16-bit free running
    wr(12'h000, 32'h41);
    wr(12'h004, 32'h12345);
    rdc("R10 narrow load", 12'h00C, 32'h2345);
    rdc("R10 limit full", 12'h004, 32'h12345);
    wr(12'h004, 1);
    ticks(0, 2);
    rdc("R9 wrap 16", 12'h00C, 32'hFFFF);
    wr(12'h010, 0);

    // R9/R10 32-bit free running
    wr(12'h000, 32'h49);
    wr(12'h004, 32'h12345);
    rdc("R10 wide load", 12'h00C, 32'h12345);
    wr(12'h004, 1);
    ticks(0, 2);
    rdc("R9 wrap 32", 12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 0);

    // R9 one-shot
    wr(12'h000, 32'h4D);
    wr(12'h004, 2);
    ticks(0, 5);
    rdc("R9 oneshot holds", 12'h00C, 0);
    chk("R9 oneshot flag", 32'(irq), 1);
    wr(12'h010, 0);
    ticks(0, 3);
    chk("R9 oneshot no refire", 32'(irq), 0);

    // R7 prescale
    wr(12'h000, 32'h5B);
    wr(12'h004, 2);
    ticks(0, 15);
    rdc("R7 div16 before", 12'h00C, 2);
    ticks(0, 1);
    rdc("R7 div16 step", 12'h00C, 1);
    wr(12'h000, 32'h6B);
    ticks(0, 255);
    rdc("R7 div256 before", 12'h00C, 1);
    ticks(0, 1);
    rdc("R7 div256 step", 12'h00C, 0);
    wr(12'h010, 0);
    wr(12'h004, 4);
    wr(12'h000, 32'h4A);
    ticks(0, 5);
    rdc("R7 stopped", 12'h00C, 4);

    // R4 read hold
    rdc("R4 read", 12'hFE4, 32'h18);
    @(negedge clk); addr = 12'hFFC;
    repeat (2) @(negedge clk);
    chk("R4 hold", rdata, 32'h18);

    finish_run();
  end
endmodule